// File: doc/BRIEF.md
# Zero-Page Operand Address Sequencer

This block turns one 8-bit zero-page operand specifier into a resolved access target for a small 8-bit processor. When the instruction sequencer raises `start`, the block latches the program counter and reads the operand byte from program memory at that address. It then pulses `pc_step` so the owner of the program counter advances it. The value of the operand byte alone selects the kind of target: an internal register, an I/O port, a direct location in the zero page, or an indirect location reached through a 16-bit pointer. That pointer is held in two consecutive zero-page bytes.

In the indirect forms the block reads the pointer, low byte first. When the low bit of the operand byte is set, the block then writes the pointer plus one back, low byte first. A one-cycle `done` pulse marks the cycle in which `tgt_kind` and `tgt_addr` are valid. `busy` stays high from the cycle after acceptance through the `done` cycle, which stalls the instruction sequencer.

The control state machine has nine states. IDLE goes to FETCH_REQ on an accepted start. FETCH_REQ always goes to FETCH_CAP. FETCH_CAP goes to PTR_LO_REQ for a pointer operand, and to DONE for any other operand. PTR_LO_REQ goes to PTR_LO_CAP, and PTR_LO_CAP goes to PTR_HI_CAP. PTR_HI_CAP goes to WB_LO for a post-increment operand, and to DONE otherwise. WB_LO goes to WB_HI, WB_HI goes to DONE, and DONE returns to IDLE. Memory is assumed to have one cycle of read latency: data addressed with `mem_rd` in one cycle appears on `mem_rdata` in the next.

Top module: `zp_operand_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `pc_step`, `mem_rd` and `mem_wr` are all low.
- R2: A `start` seen while `busy` is low is accepted. In the next cycle `mem_rd` is high and `mem_addr` equals the `pc` value presented with `start`. In the cycle after that, `pc_step` is high for exactly one cycle and is not raised again before `done`.
- R3: An operand byte Z in 0..11 gives `tgt_kind` = 0 (register) and `tgt_addr` = Z, with `done` in the third cycle after acceptance.
- R4: Z in 12..15 gives `tgt_kind` = 1 (I/O port) and `tgt_addr` = Z-12, with `done` in the third cycle after acceptance.
- R5: Z in 16..127 gives `tgt_kind` = 2 (direct memory) and `tgt_addr` = {0x00, Z}, with `done` in the third cycle after acceptance.
- R6: Z in 128..255 gives `tgt_kind` = 3 (indirect). Call P the zero-page address {0x00, Z with bit 0 cleared}. The block reads P in the third cycle and P+1 in the fourth. `tgt_addr` = {byte at P+1, byte at P}, the pointer as it was before any write-back.
- R7: An even Z of 128 or above causes no memory write, and `done` comes in the sixth cycle. An odd Z of 129 or above writes the 16-bit value pointer+1 back, including the carry from the low byte into the high byte. The low byte goes to P in the sixth cycle, the high byte goes to P+1 in the seventh, and `done` comes in the eighth.
- R8: `busy` is high in every cycle from the one after acceptance through the `done` cycle, and low in the cycle after `done`. `done` lasts one cycle. A `start` raised while `busy` is high has no effect.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to resolve the operand at `pc` |
| pc | input | 16 | Program counter addressing the operand byte |
| busy | output | 1 | Resolution in progress; stall the sequencer |
| done | output | 1 | One-cycle pulse; target outputs valid |
| pc_step | output | 1 | One-cycle pulse; advance the program counter |
| tgt_kind | output | 2 | 0 register, 1 I/O port, 2 direct memory, 3 indirect memory |
| tgt_addr | output | 16 | Register index, port index or memory address |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data is returned in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the previous cycle's read |

## Verification
The bench builds the block with its default parameters: 8-bit data, 12 registers, 4 I/O ports, the pointer range starting at 128, and a zero-page base of 0x00. With these settings all 256 operand byte values can be swept, so every class boundary (11/12, 15/16, 127/128) and both the even and odd pointer forms are covered. The zero-page pointer contents are set so that the pointer at 0xFE is 0x0FFF, which brings the carry on write-back within reach.

// File: rtl/zpseq_pkg.sv
package zpseq_pkg;

    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_IO  = 2'd1,
        TGT_MEM = 2'd2,
        TGT_PTR = 2'd3
    } zp_tgt_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_CAP,
        ST_PTR_LO_REQ,
        ST_PTR_LO_CAP,
        ST_PTR_HI_CAP,
        ST_WB_LO,
        ST_WB_HI,
        ST_DONE
    } zp_state_e;

    typedef enum logic [1:0] {
        AS_NONE,
        AS_PC,
        AS_PTR_LO,
        AS_PTR_HI
    } zp_asel_e;

endpackage

// File: rtl/zpseq_classify.sv
module zpseq_classify
    import zpseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 12,
    parameter int IO_COUNT  = 4,
    parameter int PTR_START = 128
) (
    input  logic [DATA_W-1:0] opnd,
    output zp_tgt_e           kind,
    output logic              postinc
);
    localparam logic [DATA_W-1:0] REG_END = DATA_W'(REG_COUNT);
    localparam logic [DATA_W-1:0] IO_END  = DATA_W'(REG_COUNT + IO_COUNT);
    localparam logic [DATA_W-1:0] PTR_BEG = DATA_W'(PTR_START);

    always_comb begin
        if (opnd < REG_END) begin
            kind = TGT_REG;
        end else if (opnd < IO_END) begin
            kind = TGT_IO;
        end else if (opnd < PTR_BEG) begin
            kind = TGT_MEM;
        end else begin
            kind = TGT_PTR;
        end
        postinc = (kind == TGT_PTR) && opnd[0];
    end
endmodule

// File: rtl/zpseq_ctrl.sv
module zpseq_ctrl
    import zpseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  zp_tgt_e   kind,
    input  logic      postinc,
    output logic      busy,
    output logic      done,
    output logic      pc_step,
    output logic      load_pc,
    output logic      cap_opnd,
    output logic      cap_ptr_lo,
    output logic      cap_ptr_hi,
    output logic      rd,
    output logic      wr_lo,
    output logic      wr_hi,
    output zp_asel_e  asel
);
    zp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ:  state_d = ST_FETCH_CAP;
            ST_FETCH_CAP:  state_d = (kind == TGT_PTR) ? ST_PTR_LO_REQ : ST_DONE;
            ST_PTR_LO_REQ: state_d = ST_PTR_LO_CAP;
            ST_PTR_LO_CAP: state_d = ST_PTR_HI_CAP;
            ST_PTR_HI_CAP: state_d = postinc ? ST_WB_LO : ST_DONE;
            ST_WB_LO:      state_d = ST_WB_HI;
            ST_WB_HI:      state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        pc_step    = 1'b0;
        load_pc    = 1'b0;
        cap_opnd   = 1'b0;
        cap_ptr_lo = 1'b0;
        cap_ptr_hi = 1'b0;
        rd         = 1'b0;
        wr_lo      = 1'b0;
        wr_hi      = 1'b0;
        asel       = AS_NONE;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_pc = start;
            end
            ST_FETCH_REQ: begin
                rd   = 1'b1;
                asel = AS_PC;
            end
            ST_FETCH_CAP: begin
                cap_opnd = 1'b1;
                pc_step  = 1'b1;
            end
            ST_PTR_LO_REQ: begin
                rd   = 1'b1;
                asel = AS_PTR_LO;
            end
            ST_PTR_LO_CAP: begin
                rd         = 1'b1;
                asel       = AS_PTR_HI;
                cap_ptr_lo = 1'b1;
            end
            ST_PTR_HI_CAP: begin
                cap_ptr_hi = 1'b1;
            end
            ST_WB_LO: begin
                wr_lo = 1'b1;
                asel  = AS_PTR_LO;
            end
            ST_WB_HI: begin
                wr_hi = 1'b1;
                asel  = AS_PTR_HI;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/zpseq_path.sv
module zpseq_path
    import zpseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 12,
    parameter int ZP_BASE   = 0,
    localparam int ADDR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc,
    input  logic              load_pc,
    input  logic              cap_opnd,
    input  logic              cap_ptr_lo,
    input  logic              cap_ptr_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  zp_asel_e          asel,
    input  zp_tgt_e           kind,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] opnd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] tgt_addr
);
    localparam logic [DATA_W-1:0] PAGE    = DATA_W'(ZP_BASE);
    localparam logic [DATA_W-1:0] IO_BASE = DATA_W'(REG_COUNT);
    localparam logic [DATA_W-1:0] ZERO    = '0;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] ptr_lo_q, ptr_hi_q;
    logic [ADDR_W-1:0] ptr_inc;
    logic [DATA_W-1:0] slot_even, slot_odd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            opnd_q   <= '0;
            ptr_lo_q <= '0;
            ptr_hi_q <= '0;
        end else begin
            if (load_pc)    pc_q     <= pc;
            if (cap_opnd)   opnd_q   <= rdata;
            if (cap_ptr_lo) ptr_lo_q <= rdata;
            if (cap_ptr_hi) ptr_hi_q <= rdata;
        end
    end

    assign opnd      = opnd_q;
    assign slot_even = {opnd_q[DATA_W-1:1], 1'b0};
    assign slot_odd  = {opnd_q[DATA_W-1:1], 1'b1};
    assign ptr_inc   = {ptr_hi_q, ptr_lo_q} + ADDR_W'(1);

    always_comb begin
        unique case (asel)
            AS_PC:     addr = pc_q;
            AS_PTR_LO: addr = {PAGE, slot_even};
            AS_PTR_HI: addr = {PAGE, slot_odd};
            default:   addr = '0;
        endcase
    end

    always_comb begin
        if (wr_lo) begin
            wdata = ptr_inc[DATA_W-1:0];
        end else if (wr_hi) begin
            wdata = ptr_inc[ADDR_W-1:DATA_W];
        end else begin
            wdata = '0;
        end
    end

    always_comb begin
        unique case (kind)
            TGT_REG: tgt_addr = {ZERO, opnd_q};
            TGT_IO:  tgt_addr = {ZERO, opnd_q - IO_BASE};
            TGT_MEM: tgt_addr = {PAGE, opnd_q};
            TGT_PTR: tgt_addr = {ptr_hi_q, ptr_lo_q};
            default: tgt_addr = '0;
        endcase
    end
endmodule

// File: rtl/zp_operand_seq.sv
module zp_operand_seq
    import zpseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 12,
    parameter int IO_COUNT  = 4,
    parameter int PTR_START = 128,
    parameter int ZP_BASE   = 0,
    localparam int ADDR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    output logic              busy,
    output logic              done,
    output logic              pc_step,
    output logic [1:0]        tgt_kind,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              load_pc, cap_opnd, cap_ptr_lo, cap_ptr_hi;
    logic              wr_lo, wr_hi, postinc;
    zp_asel_e          asel;
    zp_tgt_e           kind;
    logic [DATA_W-1:0] opnd, cls_in;

    // The class is needed in the capture cycle itself, before the operand register holds it.
    assign cls_in = cap_opnd ? mem_rdata : opnd;

    zpseq_classify #(
        .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
        .IO_COUNT(IO_COUNT), .PTR_START(PTR_START)
    ) u_cls (
        .opnd(cls_in), .kind(kind), .postinc(postinc)
    );

    zpseq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .postinc(postinc),
        .busy(busy), .done(done), .pc_step(pc_step), .load_pc(load_pc),
        .cap_opnd(cap_opnd), .cap_ptr_lo(cap_ptr_lo), .cap_ptr_hi(cap_ptr_hi),
        .rd(mem_rd), .wr_lo(wr_lo), .wr_hi(wr_hi), .asel(asel)
    );

    zpseq_path #(
        .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .ZP_BASE(ZP_BASE)
    ) u_path (
        .clk(clk), .rst_n(rst_n), .pc(pc), .load_pc(load_pc),
        .cap_opnd(cap_opnd), .cap_ptr_lo(cap_ptr_lo), .cap_ptr_hi(cap_ptr_hi),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .asel(asel), .kind(kind),
        .rdata(mem_rdata), .opnd(opnd), .addr(mem_addr),
        .wdata(mem_wdata), .tgt_addr(tgt_addr)
    );

    assign mem_wr   = wr_lo | wr_hi;
    assign tgt_kind = kind;
endmodule

// File: rtl/zpseq_checker.sv
module zpseq_checker
    import zpseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 12,
    parameter int IO_COUNT  = 4,
    parameter int ZP_BASE   = 0,
    localparam int ADDR_W   = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] pc,
    input logic              busy,
    input logic              done,
    input logic              pc_step,
    input logic [1:0]        tgt_kind,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr
);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !pc_step && !mem_rd && !mem_wr));

    a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (mem_rd && mem_addr == $past(pc)));

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##1 pc_step);

    a_r2_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |=> !pc_step);

    a_r3_reg_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tgt_kind == 2'(TGT_REG)) |-> tgt_addr < ADDR_W'(REG_COUNT));

    a_r4_io_index: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tgt_kind == 2'(TGT_IO)) |-> tgt_addr < ADDR_W'(IO_COUNT));

    a_r5_direct_page: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tgt_kind == 2'(TGT_MEM)) |->
            (tgt_addr[ADDR_W-1:DATA_W] == DATA_W'(ZP_BASE) &&
             tgt_addr[DATA_W-1:0] >= DATA_W'(REG_COUNT + IO_COUNT)));

    a_r7_wb_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |=> (mem_wr && mem_addr == $past(mem_addr) + 1'b1));

    a_r7_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |=> done);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind zp_operand_seq zpseq_checker #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT), .ZP_BASE(ZP_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .busy(busy), .done(done),
    .pc_step(pc_step), .tgt_kind(tgt_kind), .tgt_addr(tgt_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/zp_operand_seq_test.sv
`timescale 1ns/1ps
module zp_operand_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc = '0;
    logic        busy, done, pc_step, mem_rd, mem_wr;
    logic [1:0]  tgt_kind;
    logic [15:0] tgt_addr, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem [0:511];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    zp_operand_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .busy(busy), .done(done),
        .pc_step(pc_step), .tgt_kind(tgt_kind), .tgt_addr(tgt_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
        if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lo_of(input logic [7:0] p);
        return (p == 8'hFE) ? 8'hFF : (p ^ 8'h5A);
    endfunction

    function automatic logic [7:0] hi_of(input logic [7:0] p);
        return (p == 8'hFE) ? 8'h0F : (p + 8'h11);
    endfunction

    task automatic init_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        for (int z = 0; z < 256; z++) mem[256 + z] = 8'(z);
        for (int p = 128; p < 256; p += 2) begin
            mem[p]     = lo_of(8'(p));
            mem[p + 1] = hi_of(8'(p));
        end
    endtask

    task automatic run_one(input int z);
        int        lat, kind_e, addr_e;
        logic [7:0]  p;
        logic [15:0] m, mi, pc0;
        bit          wb;
        p   = 8'(z) & 8'hFE;
        m   = {hi_of(p), lo_of(p)};
        mi  = m + 16'd1;
        wb  = (z >= 128) && (z % 2 == 1);
        pc0 = 16'h0100 + 16'(z);
        if (z < 12)       begin kind_e = 0; addr_e = z;      lat = 3; end
        else if (z < 16)  begin kind_e = 1; addr_e = z - 12; lat = 3; end
        else if (z < 128) begin kind_e = 2; addr_e = z;      lat = 3; end
        else              begin kind_e = 3; addr_e = int'(m); lat = wb ? 8 : 6; end

        @(negedge clk);
        start = 1'b1;
        pc    = pc0;
        for (int c = 1; c <= lat + 1; c++) begin
            @(negedge clk);
            if (c <= lat) begin
                chk(busy == 1'b1, "R8 busy", int'(busy), 1);
                chk(pc_step == (c == 2), "R2 pc_step", int'(pc_step), int'(c == 2));
                chk(done == (c == lat), "R8 done timing", int'(done), int'(c == lat));
                chk(!(mem_rd && mem_wr), "R9 exclusive", int'(mem_wr), 0);
            end
            if (c == 1) begin
                chk(mem_rd && mem_addr == pc0, "R2 fetch", int'(mem_addr), int'(pc0));
                pc = 16'hBEEF;
            end
            if (c == 2 || c == 5 || c == lat)
                chk(mem_rd == 1'b0, "R2 no extra read", int'(mem_rd), 0);
            if (kind_e == 3 && c == 3)
                chk(mem_rd && mem_addr == {8'h00, p}, "R6 read low", int'(mem_addr), int'(p));
            if (kind_e == 3 && c == 4)
                chk(mem_rd && mem_addr == {8'h00, p | 8'h01}, "R6 read high", int'(mem_addr), int'(p | 8'h01));
            if (c == 6 && kind_e == 3) begin
                if (wb) chk(mem_wr && mem_addr == {8'h00, p} && mem_wdata == mi[7:0],
                            "R7 write low", int'(mem_wdata), int'(mi[7:0]));
                else    chk(!mem_wr, "R7 even no write", int'(mem_wr), 0);
            end
            if (c == 7 && wb)
                chk(mem_wr && mem_addr == {8'h00, p | 8'h01} && mem_wdata == mi[15:8],
                    "R7 write high", int'(mem_wdata), int'(mi[15:8]));
            if (c < 6 || (!wb && c <= lat))
                chk(!mem_wr, "R7 no stray write", int'(mem_wr), 0);
            if (c == lat) begin
                if (kind_e == 0)      chk(tgt_kind == 2'd0 && tgt_addr == 16'(addr_e), "R3 register", int'(tgt_addr), addr_e);
                else if (kind_e == 1) chk(tgt_kind == 2'd1 && tgt_addr == 16'(addr_e), "R4 io port", int'(tgt_addr), addr_e);
                else if (kind_e == 2) chk(tgt_kind == 2'd2 && tgt_addr == 16'(addr_e), "R5 direct", int'(tgt_addr), addr_e);
                else                  chk(tgt_kind == 2'd3 && tgt_addr == 16'(addr_e), "R6 indirect", int'(tgt_addr), addr_e);
                start = 1'b0;
            end
            if (c == lat + 1) begin
                chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", int'(busy), 0);
                if (wb) begin
                    chk(mem[p] == mi[7:0] && mem[p | 8'h01] == mi[15:8], "R7 memory image",
                        int'({mem[p | 8'h01], mem[p]}), int'(mi));
                    mem[p]         = lo_of(p);
                    mem[p | 8'h01] = hi_of(p);
                end
            end
        end
    endtask

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pc_step && !mem_rd && !mem_wr, "R1 reset",
            int'({busy, done, pc_step, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pc_step && !mem_rd && !mem_wr, "R1 after reset",
            int'({busy, done, pc_step, mem_rd, mem_wr}), 0);
        for (int z = 0; z < 256; z++) run_one(z);
        run_one(255);
        run_one(0);
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule